// File: doc/BRIEF.md
# Delegated Error Syndrome Register Unit

This unit holds the syndrome that is reported when the most privileged level hands an error down to a lower exception level. It contains one 64-bit system register. Only 25 bits of it hold state: a 24-bit detail field (bits 23:0) and an implementation-specific-syndrome flag (bit 24). The register is reached through a system-register access port, which decodes a five-field encoding and allows the access only at exception level 3.

When the exception controller raises a delivery event, the unit copies the 25 stored bits to one destination. That destination is the level-1 syndrome register, the level-2 syndrome register, or the deferred-error record when a barrier instruction deferred the error. The copy appears as a one-cycle write strobe with data. Delivery happens only when the effective delegation enable is set and the feature is enabled.

Top module: `dsyn_unit`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b110, CRn=4'b0101, CRm=4'b0010 and op2=3'b011. An access with any other encoding gets no read response and no undefined flag, and it does not change the stored value.
- R2: An access to the selected encoding with acc_level 0, 1 or 2 raises acc_undef for exactly one cycle, in the cycle after the request. It gives no read response and leaves the stored value unchanged. Level code 3 (EL3) is permitted.
- R3: Bits 63:25 always read as zero, and the values written to them are ignored.
- R4: A permitted read drives acc_rvalid high for one cycle, in the cycle after the request. acc_rdata then carries the full 64-bit value: bit 24 holds the flag and bits 23:0 hold the detail field.
- R5: A permitted write updates bits 24:0 on the next clock edge. A delivery event presented in the following cycle carries the new value.
- R6: After reset the stored flag and detail fields are zero.
- R7: A delivery event with target code 0 (EL1), 1 (EL2) or 2 (deferred record) pulses only el1_syn_we, el2_syn_we or defer_rec_we respectively. The pulse lasts one cycle and comes in the cycle after the event, with dst_syn[24:0] equal to the stored bits 24:0. Target code 3 produces no strobe.
- R8: No strobe is produced while deleg_en is 0.
- R9: While feat_en is 0, every access to the selected encoding raises acc_undef, including at level 3, and leaves the stored value unchanged. No delivery strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Feature present |
| deleg_en | input | 1 | Effective delegation enable |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_level | input | 2 | Current exception level (0..3) |
| acc_wdata | input | 64 | Write data |
| acc_rvalid | output | 1 | Read response valid |
| acc_rdata | output | 64 | Read data |
| acc_undef | output | 1 | Access flagged undefined |
| evt_valid | input | 1 | Delivery event |
| evt_target | input | 2 | 0 EL1, 1 EL2, 2 deferred record, 3 none |
| el1_syn_we | output | 1 | Level-1 syndrome write strobe |
| el2_syn_we | output | 1 | Level-2 syndrome write strobe |
| defer_rec_we | output | 1 | Deferred-error record write strobe |
| dst_syn | output | 25 | Syndrome bits delivered to the destination |

## Verification
The hardest case is the back-to-back one, where a delivery event arrives in the very cycle after a write. A late write path would then hand over the stale syndrome instead of the new one. The bench's write task returns right after the write edge, and the event task starts in the next cycle with no idle gap. The bench also reaches the undefined-access paths from both sides: it lowers the level at the correct encoding, and it clears the feature at level 3. It then reads the register at level 3 to show that its contents survived.

// File: rtl/dsyn_pkg.sv
// Package: shared widths, access encoding and destination codes for the
// delegated error syndrome unit. Assumes a 2-bit exception level code.
package dsyn_pkg;
    localparam int DATA_W = 64;
    localparam int DET_W  = 24;
    localparam int SYN_W  = DET_W + 1;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b110;
    localparam logic [3:0] ENC_CRN = 4'b0101;
    localparam logic [3:0] ENC_CRM = 4'b0010;
    localparam logic [2:0] ENC_OP2 = 3'b011;

    localparam logic [1:0] LVL_TOP = 2'd3;

    typedef enum logic [1:0] {
        TGT_EL1   = 2'd0,
        TGT_EL2   = 2'd1,
        TGT_DEFER = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;
endpackage

// File: rtl/dsyn_acc_dec.sv
// Module: access decoder. Matches the five-field encoding and splits a hit
// into permitted read, permitted write or undefined access.
// Assumes: purely combinational; the caller registers the responses.
module dsyn_acc_dec
    import dsyn_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic [1:0] level,
    input  logic       feat_en,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       bad
);
    logic hit;
    logic allowed;

    // Decode the encoding and the privilege gate.
    always_comb begin
        hit     = valid && (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
                  (crn == ENC_CRN) && (crm == ENC_CRM) && (op2 == ENC_OP2);
        allowed = feat_en && (level == LVL_TOP);
        rd_ok   = hit && allowed && !write;
        wr_ok   = hit && allowed && write;
        bad     = hit && !allowed;
    end
endmodule

// File: rtl/dsyn_store.sv
// Module: syndrome storage. Holds only the implemented low bits; the upper
// bits of the architectural word are never stored.
// Assumes: wr_en is already qualified by the decoder.
module dsyn_store #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load on a permitted write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end

    p_wr_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q == $past(wdata));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/dsyn_route.sv
// Module: delivery router. Turns an event and target code into a one-cycle
// write strobe to one destination, carrying the stored syndrome.
// Assumes: the event is a single-cycle pulse from the exception controller.
module dsyn_route
    import dsyn_pkg::*;
#(
    parameter int W = SYN_W,
    parameter int N_DST = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_valid,
    input  logic [1:0]   evt_target,
    input  logic         deleg_en,
    input  logic         feat_en,
    input  logic [W-1:0] syn,
    output logic [N_DST-1:0] dst_we,
    output logic [W-1:0] dst_syn
);
    logic go;
    logic [N_DST-1:0] sel;

    // Qualify the event and decode the target into a destination vector.
    always_comb begin
        go = evt_valid && deleg_en && feat_en;
        for (int i = 0; i < N_DST; i++)
            sel[i] = go && (evt_target == 2'(i));
    end

    // Register the strobe and data for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_we  <= '0;
            dst_syn <= '0;
        end else begin
            dst_we  <= sel;
            dst_syn <= (|sel) ? syn : '0;
        end
    end

    p_one_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_we));
    p_data_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_we) |-> dst_syn == $past(syn));
    p_deleg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_we) |-> $past(deleg_en && feat_en && evt_valid));
    p_no_tgt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_target == TGT_NONE) |=> dst_we == '0);
endmodule

// File: rtl/dsyn_unit.sv
// Module: delegated error syndrome register unit (top). Registers the access
// responses, keeps the syndrome and feeds the delivery router.
// Assumes: one access and one event per cycle at most each.
module dsyn_unit
    import dsyn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en,
    input  logic              deleg_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_op0,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [1:0]        acc_level,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_rvalid,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    input  logic              evt_valid,
    input  logic [1:0]        evt_target,
    output logic              el1_syn_we,
    output logic              el2_syn_we,
    output logic              defer_rec_we,
    output logic [SYN_W-1:0]  dst_syn
);
    localparam int RES_W = DATA_W - SYN_W;

    logic rd_ok, wr_ok, bad;
    logic [SYN_W-1:0] syn_q;
    logic [2:0] dst_we;

    dsyn_acc_dec u_dec (
        .valid(acc_valid), .write(acc_write),
        .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
        .level(acc_level), .feat_en(feat_en),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .bad(bad)
    );

    dsyn_store #(.W(SYN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok),
        .wdata(acc_wdata[SYN_W-1:0]), .q(syn_q)
    );

    dsyn_route #(.W(SYN_W), .N_DST(3)) u_route (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_target(evt_target),
        .deleg_en(deleg_en), .feat_en(feat_en), .syn(syn_q),
        .dst_we(dst_we), .dst_syn(dst_syn)
    );

    // Register the read response and the undefined flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_undef  <= 1'b0;
            acc_rdata  <= '0;
        end else begin
            acc_rvalid <= rd_ok;
            acc_undef  <= bad;
            acc_rdata  <= rd_ok ? {{RES_W{1'b0}}, syn_q} : '0;
        end
    end

    // Fan the destination vector out to named strobes.
    always_comb begin
        el1_syn_we   = dst_we[TGT_EL1];
        el2_syn_we   = dst_we[TGT_EL2];
        defer_rec_we = dst_we[TGT_DEFER];
    end

    p_undef_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_undef |-> !acc_rvalid);
    p_undef_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> $stable(syn_q));
    p_res0_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && acc_wdata[DATA_W-1:SYN_W] != '0) |=> acc_rdata[DATA_W-1:SYN_W] == '0);
    p_read_res0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> acc_rdata[DATA_W-1:SYN_W] == '0);
    p_feat_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_en && acc_valid && acc_op0 == ENC_OP0 && acc_op1 == ENC_OP1 &&
         acc_crn == ENC_CRN && acc_crm == ENC_CRM && acc_op2 == ENC_OP2) |=> acc_undef);
endmodule

// File: tb/dsyn_unit_tb.sv
module dsyn_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_en = 1'b1, deleg_en = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_op0 = 2'b11;
    logic [2:0] acc_op1 = 3'b110;
    logic [3:0] acc_crn = 4'b0101, acc_crm = 4'b0010;
    logic [2:0] acc_op2 = 3'b011;
    logic [1:0] acc_level = 2'd3;
    logic [63:0] acc_wdata = '0;
    logic acc_rvalid, acc_undef;
    logic [63:0] acc_rdata;
    logic evt_valid = 1'b0;
    logic [1:0] evt_target = 2'd0;
    logic el1_syn_we, el2_syn_we, defer_rec_we;
    logic [24:0] dst_syn;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsyn_unit u_dut (.*);

    // Vector: {level[2], wdata[64], expected readback[64], expected undef[1]}
    localparam logic [130:0] VEC [NV] = '{
        {2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_01FF_FFFF, 1'b0},
        {2'd2, 64'h0000_0000_0000_1234, 64'h0000_0000_01FF_FFFF, 1'b1},
        {2'd3, 64'h0000_0000_0100_0000, 64'h0000_0000_0100_0000, 1'b0},
        {2'd1, 64'h0000_0000_0000_0005, 64'h0000_0000_0100_0000, 1'b1},
        {2'd0, 64'h0000_0000_0000_0007, 64'h0000_0000_0100_0000, 1'b1},
        {2'd3, 64'hABCD_0000_00AB_CDEF, 64'h0000_0000_00AB_CDEF, 1'b0},
        {2'd3, 64'hFE00_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
        {2'd3, 64'h0000_0000_00C0_FFEE, 64'h0000_0000_00C0_FFEE, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One access; returns at the negedge where its response is visible.
    task automatic access(input bit wr, input logic [2:0] op2v, input logic [1:0] lvl, input logic [63:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_op2 = op2v; acc_level = lvl; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_op2 = 3'b011; acc_level = 2'd3;
    endtask

    task automatic event_go(input logic [1:0] tgt);
        evt_valid = 1'b1; evt_target = tgt;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [63:0] exp);
        access(1'b0, 3'b011, 2'd3, 64'd0);
        chk(acc_rvalid === 1'b1, tag, {63'd0, acc_rvalid}, 64'd1);
        chk(acc_rdata === exp, tag, acc_rdata, exp);
    endtask

    task automatic strobe_check(input string tag, input logic [2:0] exp_we, input logic [24:0] exp_d);
        chk({defer_rec_we, el2_syn_we, el1_syn_we} === exp_we, tag,
            {61'd0, defer_rec_we, el2_syn_we, el1_syn_we}, {61'd0, exp_we});
        if (exp_we != 3'b000)
            chk(dst_syn === exp_d, tag, {39'd0, dst_syn}, {39'd0, exp_d});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        chk(acc_undef === 1'b0 && acc_rvalid === 1'b0, "R6 idle outputs",
            {62'd0, acc_undef, acc_rvalid}, 64'd0);
        read_check("R6 reset value", 64'd0);

        // Table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            access(1'b1, 3'b011, VEC[i][130:129], VEC[i][128:65]);
            chk(acc_undef === VEC[i][0], "R2 write undef flag", {63'd0, acc_undef}, {63'd0, VEC[i][0]});
            chk(acc_rvalid === 1'b0, "R4 no rvalid on write", {63'd0, acc_rvalid}, 64'd0);
            read_check("R3 table readback", VEC[i][64:1]);
        end

        // R2: read below level 3
        access(1'b0, 3'b011, 2'd1, 64'd0);
        chk(acc_undef === 1'b1 && acc_rvalid === 1'b0, "R2 low read",
            {62'd0, acc_undef, acc_rvalid}, 64'd2);
        @(negedge clk);
        chk(acc_undef === 1'b0, "R2 undef one cycle", {63'd0, acc_undef}, 64'd0);

        // R1: other encoding
        access(1'b1, 3'b010, 2'd3, 64'h0000_0000_0012_3456);
        chk(acc_undef === 1'b0 && acc_rvalid === 1'b0, "R1 miss silent",
            {62'd0, acc_undef, acc_rvalid}, 64'd0);
        access(1'b0, 3'b111, 2'd3, 64'd0);
        chk(acc_rvalid === 1'b0, "R1 miss no read", {63'd0, acc_rvalid}, 64'd0);
        read_check("R1 miss no write", 64'h0000_0000_00C0_FFEE);

        // R5 + R7: write, then event in the very next cycle
        access(1'b1, 3'b011, 2'd3, 64'h0000_0000_0155_AA55);
        event_go(2'd0);
        strobe_check("R5 R7 EL1 back-to-back", 3'b001, 25'h155_AA55);
        @(negedge clk);
        strobe_check("R7 strobe one cycle", 3'b000, 25'd0);
        event_go(2'd1);
        strobe_check("R7 EL2", 3'b010, 25'h155_AA55);
        access(1'b1, 3'b011, 2'd3, 64'h0000_0000_0000_0ABC);
        event_go(2'd2);
        strobe_check("R7 deferred", 3'b100, 25'h000_0ABC);
        event_go(2'd3);
        strobe_check("R7 target none", 3'b000, 25'd0);

        // R8: delegation disabled
        deleg_en = 1'b0;
        event_go(2'd0);
        strobe_check("R8 deleg off EL1", 3'b000, 25'd0);
        event_go(2'd2);
        strobe_check("R8 deleg off defer", 3'b000, 25'd0);
        deleg_en = 1'b1;

        // R9: feature disabled
        feat_en = 1'b0;
        access(1'b1, 3'b011, 2'd3, 64'h0000_0000_0111_1111);
        chk(acc_undef === 1'b1, "R9 write undef", {63'd0, acc_undef}, 64'd1);
        access(1'b0, 3'b011, 2'd3, 64'd0);
        chk(acc_undef === 1'b1 && acc_rvalid === 1'b0, "R9 read undef",
            {62'd0, acc_undef, acc_rvalid}, 64'd2);
        event_go(2'd1);
        strobe_check("R9 no delivery", 3'b000, 25'd0);
        feat_en = 1'b1;
        read_check("R9 value kept", 64'h0000_0000_0000_0ABC);

        // R6: reset mid-run clears fields
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R6 after reset", 64'd0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule